// File: doc/BRIEF.md
# Synchronous Burst Clock and First-Data Latency Generator

This block drives the external memory clock for a synchronous burst transfer and marks the memory clock edge where the first datum is exchanged. A transfer starts when a start request is seen while the block is idle and synchronous burst mode is enabled. At that moment the block samples a 4-bit divide setting and a 4-bit latency setting. The memory clock then runs at the system clock rate divided by (divide setting + 1). It starts from a low level.

The latency is counted in memory clock periods, not in system clock cycles. It runs for (latency setting + 2) periods, measured from the first rising edge of the memory clock. A one-cycle strobe marks the rising edge at the end of that count. Busy covers the whole interval from the accepted request to the strobe. When synchronous burst mode is off, a start request is ignored and neither setting has any effect. The rest of the burst after the first beat is handled elsewhere.

Top module: `burst_clk_gen`

## Requirements
- R1: With a divide setting D > 0 the ratio is N = D + 1. In each memory clock period, mem_clk_o is low for floor(N/2) system cycles and then high for ceil(N/2) system cycles. The first period begins low in the first cycle after the start request is sampled.
- R2: With a divide setting of 0, mem_clk_o is the system clock gated by an enable. It pulses high in the high phase of every system cycle while busy_o is high, and it is low otherwise.
- R3: first_valid_o is high for exactly one system cycle. Counting the cycle after the start is sampled as cycle 1, that cycle is 1 + floor(N/2) + (L + 2)·N, where L is the latency setting. This is the rising edge that comes L + 2 memory clock periods after the first rising edge.
- R4: A start request sampled while idle with burst_en_i high raises busy_o on the following cycle.
- R5: busy_o stays high through the first_valid_o cycle and is low on the cycle after it.
- R6: A start request with burst_en_i low is ignored. busy_o and first_valid_o stay low, and mem_clk_o stays low.
- R7: A start request while busy_o is high is ignored. The transfer in progress keeps its timing.
- R8: Changes to div_cfg_i or lat_cfg_i during a transfer do not change that transfer's clock or strobe timing.
- R9: After reset, busy_o, first_valid_o and mem_clk_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_cfg_i | input | 4 | Divide setting; ratio is value + 1 |
| lat_cfg_i | input | 4 | Latency setting; latency is value + 2 memory clock periods |
| burst_en_i | input | 1 | Synchronous burst mode enable |
| start_i | input | 1 | Transfer start request |
| mem_clk_o | output | 1 | Divided memory clock |
| busy_o | output | 1 | Transfer in progress |
| first_valid_o | output | 1 | One-cycle strobe at the first-data clock edge |

## Verification
The bench builds the block with its default 4-bit divide and latency widths. This makes the full setting space reachable: ratios from 1x to 16x, including the gated 1x path, and latencies from 2 to 17 periods. Directed runs cover the extreme pairs (0,0), (15,15) and small odd and even ratios. Seeded random runs mix the other settings with mid-transfer setting changes and repeated start requests. Each run checks the clock level, busy and the strobe cycle on every cycle.

// File: rtl/burst_clk_pkg.sv
`timescale 1ns/1ps
package burst_clk_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } xfer_state_e;
endpackage

// File: rtl/burst_ctrl.sv
`timescale 1ns/1ps
module burst_ctrl
  import burst_clk_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             burst_en_i,
  input  logic             done_i,
  input  logic [DIV_W-1:0] div_cfg_i,
  input  logic [LAT_W-1:0] lat_cfg_i,
  output logic             run_o,
  output logic             launch_o,
  output logic             fast_nxt_o,
  output logic [DIV_W-1:0] div_o,
  output logic [LAT_W-1:0] lat_o
);
  xfer_state_e      st_q, st_d;
  logic [DIV_W-1:0] div_q, div_nxt;
  logic [LAT_W-1:0] lat_q;

  assign launch_o = (st_q == ST_IDLE) && start_i && burst_en_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (launch_o) st_d = ST_RUN;
      ST_RUN:  if (done_i)   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // enable for the gated 1x clock, looked up one half cycle ahead
  assign div_nxt    = launch_o ? div_cfg_i : div_q;
  assign fast_nxt_o = (st_d == ST_RUN) && (div_nxt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      div_q <= '1;
      lat_q <= '1;
    end else begin
      st_q <= st_d;
      if (launch_o) begin
        div_q <= div_cfg_i;
        lat_q <= lat_cfg_i;
      end
    end
  end

  assign run_o = (st_q == ST_RUN);
  assign div_o = div_q;
  assign lat_o = lat_q;
endmodule

// File: rtl/burst_clk_div.sv
`timescale 1ns/1ps
module burst_clk_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             run_i,
  input  logic             done_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             hi_o,
  output logic             rise_o
);
  localparam int N_W = DIV_W + 1;

  logic [N_W-1:0]   ratio;
  logic [DIV_W-1:0] lo_len;
  logic [DIV_W-1:0] ph_q, ph_d;
  logic             hi_q, hi_d;

  assign ratio  = {1'b0, div_i} + N_W'(1);
  assign lo_len = ratio[N_W-1:1];

  always_comb begin
    if (launch_i)               ph_d = '0;
    else if (run_i && !done_i)  ph_d = (ph_q == div_i) ? '0 : ph_q + DIV_W'(1);
    else                        ph_d = '0;
    // high phase only for ratios above 1x; 1x uses the gated path
    hi_d = run_i && !done_i && !launch_i && (lo_len != '0) && (ph_d >= lo_len);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
      hi_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      hi_q <= hi_d;
    end
  end

  assign hi_o   = hi_q;
  assign rise_o = run_i && (ph_q == lo_len);
endmodule

// File: rtl/burst_lat_cnt.sv
`timescale 1ns/1ps
module burst_lat_cnt #(
  parameter int LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             run_i,
  input  logic             rise_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             hit_o
);
  localparam int E_W = LAT_W + 1;

  logic [E_W-1:0] edge_q;
  logic [E_W-1:0] target;

  assign target = {1'b0, lat_i} + E_W'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              edge_q <= '0;
    else if (launch_i)        edge_q <= '0;
    else if (run_i && rise_i) edge_q <= edge_q + E_W'(1);
  end

  assign hit_o = run_i && rise_i && (edge_q == target);
endmodule

// File: rtl/burst_clk_out.sv
`timescale 1ns/1ps
module burst_clk_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_nxt_i,
  input  logic hi_i,
  output logic mem_clk_o
);
  logic en_q;

  // falling-edge enable keeps the gated clock free of glitches
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= fast_nxt_i;
  end

  assign mem_clk_o = (clk_i & en_q) | hi_i;
endmodule

// File: rtl/burst_clk_gen.sv
`timescale 1ns/1ps
module burst_clk_gen #(
  parameter int DIV_W = 4,
  parameter int LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_cfg_i,
  input  logic [LAT_W-1:0] lat_cfg_i,
  input  logic             burst_en_i,
  input  logic             start_i,
  output logic             mem_clk_o,
  output logic             busy_o,
  output logic             first_valid_o
);
  logic             run, launch, fast_nxt, hi, rise, hit;
  logic [DIV_W-1:0] div_q;
  logic [LAT_W-1:0] lat_q;

  burst_ctrl #(.DIV_W(DIV_W), .LAT_W(LAT_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .burst_en_i(burst_en_i),
    .done_i    (hit),
    .div_cfg_i (div_cfg_i),
    .lat_cfg_i (lat_cfg_i),
    .run_o     (run),
    .launch_o  (launch),
    .fast_nxt_o(fast_nxt),
    .div_o     (div_q),
    .lat_o     (lat_q)
  );

  burst_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .run_i   (run),
    .done_i  (hit),
    .div_i   (div_q),
    .hi_o    (hi),
    .rise_o  (rise)
  );

  burst_lat_cnt #(.LAT_W(LAT_W)) u_lat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .run_i   (run),
    .rise_i  (rise),
    .lat_i   (lat_q),
    .hit_o   (hit)
  );

  burst_clk_out u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fast_nxt_i(fast_nxt),
    .hi_i      (hi),
    .mem_clk_o (mem_clk_o)
  );

  assign busy_o        = run;
  assign first_valid_o = hit;
endmodule

// File: rtl/burst_clk_gen_chk.sv
`timescale 1ns/1ps
module burst_clk_gen_chk #(
  parameter int DIV_W = 4,
  parameter int LAT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             burst_en_i,
  input logic             busy_o,
  input logic             first_valid_o,
  input logic             mem_clk_o,
  input logic [DIV_W-1:0] div_q,
  input logic [LAT_W-1:0] lat_q
);
  assert_accept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && burst_en_i) |=> busy_o);

  assert_ignore_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !burst_en_i) |=> !busy_o);

  assert_strobe_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_valid_o |-> busy_o);

  assert_clear_after_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_valid_o |=> (!busy_o && !first_valid_o));

  assert_idle_clk_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_clk_o);

  assert_hold_div_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(div_q));

  assert_hold_lat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(lat_q));
endmodule

bind burst_clk_gen burst_clk_gen_chk #(.DIV_W(DIV_W), .LAT_W(LAT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .burst_en_i   (burst_en_i),
  .busy_o       (busy_o),
  .first_valid_o(first_valid_o),
  .mem_clk_o    (mem_clk_o),
  .div_q        (div_q),
  .lat_q        (lat_q)
);

// File: tb/burst_clk_gen_tb_top.sv
`timescale 1ns/1ps
module burst_clk_gen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] div_cfg_i = 4'hf;
  logic [3:0] lat_cfg_i = 4'hf;
  logic       burst_en_i = 1'b0;
  logic       start_i = 1'b0;
  logic       mem_clk_o, busy_o, first_valid_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i; // 50 MHz

  burst_clk_gen dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .div_cfg_i    (div_cfg_i),
    .lat_cfg_i    (lat_cfg_i),
    .burst_en_i   (burst_en_i),
    .start_i      (start_i),
    .mem_clk_o    (mem_clk_o),
    .busy_o       (busy_o),
    .first_valid_o(first_valid_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int strobe_cycle(input int d, input int l);
    int n = d + 1;
    return 1 + n / 2 + (l + 2) * n;
  endfunction

  function automatic bit clk_level(input int d, input int k, input int endk);
    int n = d + 1;
    if (k > endk) return 1'b0;
    if (n == 1) return 1'b1; // sampled in the system clock high phase
    return ((k - 1) % n) >= (n / 2);
  endfunction

  task automatic run_xfer(input int d, input int l, input bit disturb);
    int endk, fv_k, fv_cnt, bad_busy, bad_clk;
    endk = strobe_cycle(d, l);
    fv_k = -1; fv_cnt = 0; bad_busy = 0; bad_clk = 0;
    @(posedge clk_i); #5;
    div_cfg_i = 4'(d); lat_cfg_i = 4'(l); burst_en_i = 1'b1; start_i = 1'b1;
    for (int k = 1; k <= endk + 2; k++) begin
      @(posedge clk_i); #5;
      if (busy_o !== (k <= endk)) bad_busy++;
      if (mem_clk_o !== clk_level(d, k, endk)) bad_clk++;
      if (first_valid_o) begin fv_cnt++; fv_k = k; end
      if (k == 1) start_i = 1'b0;
      if (disturb && k == 2) start_i = 1'b1;
      if (disturb && k == 3) begin
        start_i = 1'b0;
        div_cfg_i = 4'($urandom);
        lat_cfg_i = 4'($urandom);
      end
    end
    chk(fv_cnt == 1 && fv_k == endk, "R3", fv_k, endk);
    chk(bad_busy == 0, "R4 R5 busy window", bad_busy, 0);
    if (d == 0) chk(bad_clk == 0, "R2", bad_clk, 0);
    else        chk(bad_clk == 0, "R1", bad_clk, 0);
    if (disturb) begin
      chk(fv_k == endk, "R7 R8 timing after disturbance", fv_k, endk);
    end
  endtask

  task automatic check_ignored();
    int bad = 0;
    @(posedge clk_i); #5;
    burst_en_i = 1'b0; start_i = 1'b1; div_cfg_i = 4'h0; lat_cfg_i = 4'h0;
    for (int k = 1; k <= 30; k++) begin
      @(posedge clk_i); #5;
      if (busy_o || first_valid_o || mem_clk_o) bad++;
    end
    start_i = 1'b0;
    chk(bad == 0, "R6", bad, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk_i);
    #5;
    chk(!busy_o && !first_valid_o && !mem_clk_o, "R9",
        {busy_o, first_valid_o, mem_clk_o}, 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #5;
    chk(!busy_o && !first_valid_o && !mem_clk_o, "R9 after release",
        {busy_o, first_valid_o, mem_clk_o}, 0);

    run_xfer(0, 0, 1'b0);
    run_xfer(15, 15, 1'b0);
    run_xfer(1, 0, 1'b0);
    run_xfer(2, 1, 1'b0);
    run_xfer(0, 15, 1'b1);
    run_xfer(15, 0, 1'b1);
    check_ignored();
    for (int i = 0; i < 20; i++) begin
      run_xfer(int'($urandom_range(15, 0)), int'($urandom_range(15, 0)),
               bit'($urandom_range(1, 0)));
    end
    check_ignored();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule